// File: doc/BRIEF.md
# UART Transmit Holding and Shift Path

This block is the send half of a UART that runs from an oversampling enable pulsed sixteen times per bit. A CPU-side register interface writes bytes into a holding stage. Depending on a mode input, that stage is a single byte register or a sixteen-byte first-in first-out buffer. A shift register takes bytes from the holding stage one at a time and drives them onto the serial line as 8N1 frames. When more data is waiting, one frame follows the next with no idle time between them.

Three flags go back to software. One says the holding stage can accept a write. One says the holding stage holds no byte. One says both the holding stage and the shift register are idle. A transmit-empty interrupt is raised when the shift register takes the last waiting byte. Software clears it by reading the interrupt status, by writing new data, or by disabling the interrupt.

Top module: `uart_tx_path`

## Requirements
- R1: After reset `txd` is 1, `hold_ready` is 1, `hold_empty` is 1, `tx_idle` is 1 and `irq` is 0.
- R2: Each frame is one start bit of 0, then eight data bits with bit 0 first, then one stop bit of 1. Every bit lasts 16 pulses of `tick16`. A frame begins on the first `tick16` pulse on which a byte is waiting and the shifter is idle. `txd` is 1 while no frame is in progress and changes only on cycles with `tick16` high.
- R3: With `fifo_en` = 1 the holding stage keeps up to 16 bytes and sends them in write order. `hold_ready` is 0 exactly when 16 bytes are held, and a write made while `hold_ready` is 0 is dropped.
- R4: With `fifo_en` = 0 the holding stage keeps one byte. A second write made before that byte moves to the shifter is dropped.
- R5: If a byte is waiting when a stop bit ends, the next start bit begins on the very next `tick16` pulse, so consecutive frame starts are exactly 160 pulses apart.
- R6: `hold_empty` is 1 whenever no byte waits in the holding stage, including right after the last waiting byte moves into the shifter. It is 0 while any byte waits.
- R7: `tx_idle` is 1 only when `hold_empty` is 1 and the stop bit of the last frame has completed.
- R8: When `irq_en` is 1, a move into the shifter that leaves the holding stage empty sets `irq` in the next cycle.
- R9: A one-cycle pulse on `isr_rd` clears `irq` in the next cycle, unless a new setting event occurs in the same cycle.
- R10: A write that the holding stage accepts clears `irq` in the next cycle.
- R11: While `irq_en` is 0, `irq` is 0 from the next cycle on and no transfer sets it.
- R12: A change of `fifo_en` discards all bytes waiting in the holding stage. Writes made in the cycle of the change are dropped too.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| tick16 | input | 1 | One-cycle enable at sixteen times the bit rate |
| fifo_en | input | 1 | 1: sixteen-byte buffer; 0: single holding register |
| irq_en | input | 1 | Transmit-empty interrupt enable |
| wr_en | input | 1 | Byte write strobe |
| wr_data | input | 8 | Byte to send |
| isr_rd | input | 1 | Interrupt status read strobe (clears `irq`) |
| txd | output | 1 | Serial output line, idle high |
| hold_ready | output | 1 | Holding stage can accept a write |
| hold_empty | output | 1 | Holding stage holds no byte |
| tx_idle | output | 1 | Holding stage and shift register both idle |
| irq | output | 1 | Transmit-empty interrupt |

## Verification
The assertions assume that `tick16` is a single-cycle pulse and that `isr_rd` and `wr_en` are single-cycle strobes sampled on the rising edge. They also assume that `fifo_en` changes only as a deliberate reconfiguration. The bench drives every input at the falling edge. It keeps `tick16` at one pulse every four cycles, or holds it low to freeze the shifter while the holding stage is filled. In the random phase it writes only while `hold_ready` is 1, so the stream it expects stays well defined. Overfull writes are made only in directed cases where the dropped bytes are known in advance.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  typedef enum logic {
    SH_IDLE = 1'b0,
    SH_BUSY = 1'b1
  } sh_state_t;
endpackage

// File: rtl/uart_tx_hold.sv
module uart_tx_hold #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fifo_en,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              pop,
  output logic [DATA_W-1:0] rd_data,
  output logic              hold_ready,
  output logic              hold_empty,
  output logic              push_ok,
  output logic              drained
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d, cap;
  logic              mode_q, mode_chg, pop_ok;

  always_comb begin
    cap        = fifo_en ? CNT_W'(DEPTH) : CNT_W'(1);
    mode_chg   = (fifo_en != mode_q);
    hold_empty = (cnt_q == '0);
    hold_ready = (cnt_q < cap) && !mode_chg;
    push_ok    = wr_en && hold_ready;
    pop_ok     = pop && !hold_empty && !mode_chg;
    drained    = pop_ok && !push_ok && (cnt_q == CNT_W'(1));
    rd_data    = mem_q[rd_ptr_q];
    wr_ptr_d   = wr_ptr_q;
    rd_ptr_d   = rd_ptr_q;
    cnt_d      = cnt_q;
    if (mode_chg) begin
      wr_ptr_d = '0;
      rd_ptr_d = '0;
      cnt_d    = '0;
    end else begin
      if (push_ok)
        wr_ptr_d = (wr_ptr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr_q + 1'b1;
      if (pop_ok)
        rd_ptr_d = (rd_ptr_q == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr_q + 1'b1;
      if (push_ok && !pop_ok)      cnt_d = cnt_q + 1'b1;
      else if (pop_ok && !push_ok) cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
      mode_q   <= 1'b1;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
      mode_q   <= fifo_en;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem_q[wr_ptr_q] <= wr_data;
  end

  // R3
  cnt_within_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_chg |-> (cnt_q <= cap));
  // R12
  mode_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg |=> hold_empty);
  // R3
  full_write_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !hold_ready && !pop_ok && !mode_chg) |=> $stable(cnt_q));
endmodule

// File: rtl/uart_tx_shift.sv
module uart_tx_shift #(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              has_data,
  input  logic [DATA_W-1:0] din,
  output logic              load,
  output logic              busy,
  output logic              txd
);
  import uart_tx_pkg::*;

  localparam int TC_W = $clog2(OVS);
  localparam int BI_W = $clog2(DATA_W + 2);
  localparam logic [BI_W-1:0] LAST_BIT = BI_W'(DATA_W + 1);

  sh_state_t         state_q, state_d;
  logic [TC_W-1:0]   tcnt_q, tcnt_d;
  logic [BI_W-1:0]   bidx_q, bidx_d;
  logic [DATA_W-1:0] sreg_q, sreg_d;
  logic              bit_end, frame_end, in_data;

  always_comb begin
    busy      = (state_q == SH_BUSY);
    bit_end   = busy && tick && (tcnt_q == TC_W'(OVS - 1));
    frame_end = bit_end && (bidx_q == LAST_BIT);
    in_data   = (bidx_q != '0) && (bidx_q != LAST_BIT);
    load      = tick && has_data && (!busy || frame_end);
    state_d   = state_q;
    tcnt_d    = tcnt_q;
    bidx_d    = bidx_q;
    sreg_d    = sreg_q;
    if (load) begin
      state_d = SH_BUSY;
      tcnt_d  = '0;
      bidx_d  = '0;
      sreg_d  = din;
    end else if (busy && tick) begin
      if (!bit_end) begin
        tcnt_d = tcnt_q + 1'b1;
      end else begin
        tcnt_d = '0;
        if (frame_end) begin
          state_d = SH_IDLE;
          bidx_d  = '0;
        end else begin
          bidx_d = bidx_q + 1'b1;
          if (in_data) sreg_d = sreg_q >> 1;
        end
      end
    end
    if (!busy)                txd = 1'b1;
    else if (bidx_q == '0)    txd = 1'b0;
    else if (!in_data)        txd = 1'b1;
    else                      txd = sreg_q[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SH_IDLE;
      tcnt_q  <= '0;
      bidx_q  <= '0;
      sreg_q  <= '0;
    end else begin
      state_q <= state_d;
      tcnt_q  <= tcnt_d;
      bidx_q  <= bidx_d;
      sreg_q  <= sreg_d;
    end
  end

  // R2
  start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !txd);
  // R2
  line_moves_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(txd));
  // R5
  no_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && has_data) |=> busy);
endmodule

// File: rtl/uart_tx_irq.sv
module uart_tx_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic irq_en,
  input  logic set_evt,
  input  logic rd_clr,
  input  logic wr_clr,
  output logic irq
);
  logic irq_q, irq_d;

  always_comb begin
    irq_d = irq_q;
    if (!irq_en)               irq_d = 1'b0;
    else if (set_evt)          irq_d = 1'b1;
    else if (rd_clr || wr_clr) irq_d = 1'b0;
    irq = irq_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  // R8
  irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en && set_evt) |=> irq);
  // R9
  irq_read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && !set_evt) |=> !irq);
  // R10
  irq_write_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_clr && !set_evt) |=> !irq);
  // R11
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |=> !irq);
endmodule

// File: rtl/uart_tx_path.sv
module uart_tx_path #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick16,
  input  logic              fifo_en,
  input  logic              irq_en,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              isr_rd,
  output logic              txd,
  output logic              hold_ready,
  output logic              hold_empty,
  output logic              tx_idle,
  output logic              irq
);
  logic [DATA_W-1:0] head;
  logic              load, busy, push_ok, drained;

  uart_tx_hold #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_hold (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .wr_en(wr_en),
    .wr_data(wr_data), .pop(load), .rd_data(head), .hold_ready(hold_ready),
    .hold_empty(hold_empty), .push_ok(push_ok), .drained(drained)
  );

  uart_tx_shift #(.DATA_W(DATA_W), .OVS(OVS)) u_shift (
    .clk(clk), .rst_n(rst_n), .tick(tick16), .has_data(!hold_empty),
    .din(head), .load(load), .busy(busy), .txd(txd)
  );

  uart_tx_irq u_irq (
    .clk(clk), .rst_n(rst_n), .irq_en(irq_en), .set_evt(drained),
    .rd_clr(isr_rd), .wr_clr(push_ok), .irq(irq)
  );

  assign tx_idle = hold_empty && !busy;

  // R7
  idle_implies_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_idle |-> (hold_empty && txd));
  // R6
  empty_after_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drained |=> hold_empty);
endmodule

// File: tb/uart_tx_path_tb.sv
module uart_tx_path_tb;
  logic       clk = 1'b0;
  logic       rst_n, tick16, fifo_en, irq_en, wr_en, isr_rd;
  logic [7:0] wr_data;
  logic       txd, hold_ready, hold_empty, tx_idle, irq;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit tick_on = 1'b0;
  int phase = 0, tick_cnt = 0;
  int rx_state = 0, rx_cnt = 0;
  logic [7:0] rx_byte;
  logic prev_txd = 1'b1;
  logic [7:0] rx_q[$];
  logic [7:0] exp_q[$];
  int start_q[$];

  always #10 clk = ~clk;

  uart_tx_path u_dut (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .fifo_en(fifo_en),
    .irq_en(irq_en), .wr_en(wr_en), .wr_data(wr_data), .isr_rd(isr_rd),
    .txd(txd), .hold_ready(hold_ready), .hold_empty(hold_empty),
    .tx_idle(tx_idle), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  function automatic bit accepts(input int idx, input int cap);
    return idx < cap;
  endfunction

  function automatic logic frame_bit(input logic [7:0] b, input int k);
    return b[k];
  endfunction

  // tick generator and serial receiver, one process so ordering is fixed
  always @(negedge clk) begin
    if (tick16 === 1'b1) tick_cnt++;
    if (rx_state == 0) begin
      if (prev_txd === 1'b1 && txd === 1'b0) begin
        rx_state = 1; rx_cnt = 0; rx_byte = '0;
        start_q.push_back(tick_cnt);
      end
    end else if (tick16 === 1'b1) begin
      rx_cnt++;
      if (rx_cnt == 8)
        chk(txd === 1'b0, "R2", "start bit middle", int'(txd), 0);
      else if (rx_cnt > 8 && rx_cnt < 152 && (rx_cnt - 8) % 16 == 0)
        rx_byte[(rx_cnt - 8) / 16 - 1] = txd;
      else if (rx_cnt == 152) begin
        chk(txd === 1'b1, "R2", "stop bit middle", int'(txd), 1);
        rx_q.push_back(rx_byte);
        rx_state = 0;
      end
    end
    prev_txd = txd;
    phase = (phase + 1) % 4;
    tick16 = tick_on && (phase == 0);
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      chk(1'b0, "WDOG", "watchdog expired", cyc, 0);
      report();
    end
  end

  task automatic write_byte(input logic [7:0] b);
    @(negedge clk); wr_en = 1'b1; wr_data = b;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic wait_rx(input int n);
    while (rx_q.size() < n) @(negedge clk);
  endtask

  task automatic wait_ticks(input int n);
    int t0 = tick_cnt;
    while (tick_cnt - t0 < n) @(negedge clk);
  endtask

  task automatic compare_all(input string req);
    while (exp_q.size() > 0) begin
      logic [7:0] e = exp_q.pop_front();
      logic [7:0] a = (rx_q.size() > 0) ? rx_q.pop_front() : 8'hxx;
      chk(a === e, req, "received byte", int'(a), int'(e));
    end
    chk(rx_q.size() == 0, req, "extra bytes", rx_q.size(), 0);
  endtask

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0; tick16 = 1'b0; fifo_en = 1'b1; irq_en = 1'b1;
    wr_en = 1'b0; isr_rd = 1'b0; wr_data = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(txd === 1'b1, "R1", "txd", int'(txd), 1);
    chk(hold_ready === 1'b1, "R1", "hold_ready", int'(hold_ready), 1);
    chk(hold_empty === 1'b1, "R1", "hold_empty", int'(hold_empty), 1);
    chk(tx_idle === 1'b1, "R1", "tx_idle", int'(tx_idle), 1);
    chk(irq === 1'b0, "R1", "irq", int'(irq), 0);

    // R3 fill 16-byte buffer with shifter frozen, 17th write dropped
    for (int i = 0; i < 17; i++) begin
      logic [7:0] b = 8'($urandom);
      if (i == 16) begin
        chk(hold_ready === 1'b0, "R3", "ready when full", int'(hold_ready), 0);
        chk(hold_empty === 1'b0, "R6", "empty when full", int'(hold_empty), 0);
      end
      write_byte(b);
      if (accepts(i, 16)) exp_q.push_back(b);
    end
    start_q.delete();
    tick_on = 1'b1;
    wait_rx(16);
    chk(tx_idle === 1'b0, "R7", "idle during last stop bit", int'(tx_idle), 0);
    chk(hold_empty === 1'b1, "R6", "empty after last load", int'(hold_empty), 1);
    chk(irq === 1'b1, "R8", "irq after drain", int'(irq), 1);
    compare_all("R3");
    for (int i = 1; i < 16; i++)
      chk(start_q[i] - start_q[i-1] == 160, "R5", "frame spacing",
          start_q[i] - start_q[i-1], 160);
    wait_ticks(12);
    chk(tx_idle === 1'b1, "R7", "idle after stop", int'(tx_idle), 1);
    chk(txd === 1'b1, "R2", "idle line", int'(txd), 1);

    // R9 read clears
    @(negedge clk); isr_rd = 1'b1;
    @(negedge clk); isr_rd = 1'b0;
    chk(irq === 1'b0, "R9", "irq after read", int'(irq), 0);

    // R10 write clears
    begin
      logic [7:0] b = 8'h3C;
      write_byte(b); exp_q.push_back(b);
      wait_rx(1); compare_all("R2");
      chk(irq === 1'b1, "R8", "irq after single frame", int'(irq), 1);
      tick_on = 1'b0; wait_ticks(0); repeat (8) @(negedge clk);
      b = 8'hA5;
      @(negedge clk); wr_en = 1'b1; wr_data = b;
      @(negedge clk); wr_en = 1'b0;
      chk(irq === 1'b0, "R10", "irq after write", int'(irq), 0);
      exp_q.push_back(b);
      tick_on = 1'b1; wait_rx(1); compare_all("R2");
      wait_ticks(12);
      chk(irq === 1'b1, "R8", "irq set again", int'(irq), 1);
    end

    // R11 disable clears and masks
    @(negedge clk); irq_en = 1'b0;
    @(negedge clk);
    chk(irq === 1'b0, "R11", "irq after disable", int'(irq), 0);
    write_byte(8'h81); exp_q.push_back(8'h81);
    wait_rx(1); compare_all("R2");
    wait_ticks(20);
    chk(irq === 1'b0, "R11", "irq stays masked", int'(irq), 0);
    irq_en = 1'b1;

    // R4 single register mode
    tick_on = 1'b0; repeat (8) @(negedge clk);
    fifo_en = 1'b0; repeat (2) @(negedge clk);
    write_byte(8'h5A);
    chk(hold_ready === 1'b0, "R4", "ready with one byte", int'(hold_ready), 0);
    write_byte(8'hC3);
    exp_q.push_back(8'h5A);
    tick_on = 1'b1;
    wait_rx(1); wait_ticks(400);
    compare_all("R4");

    // R12 mode change discards waiting bytes
    tick_on = 1'b0; repeat (8) @(negedge clk);
    fifo_en = 1'b1; repeat (2) @(negedge clk);
    for (int i = 0; i < 3; i++) write_byte(8'(i + 8'h10));
    chk(hold_empty === 1'b0, "R6", "empty with bytes", int'(hold_empty), 0);
    @(negedge clk); fifo_en = 1'b0;
    @(negedge clk);
    chk(hold_empty === 1'b1, "R12", "empty after mode change", int'(hold_empty), 1);
    tick_on = 1'b1; wait_ticks(300);
    chk(rx_q.size() == 0, "R12", "frames after flush", rx_q.size(), 0);
    chk(txd === 1'b1, "R12", "line after flush", int'(txd), 1);
    fifo_en = 1'b1; repeat (2) @(negedge clk);

    // random phase: R3 order and R2 framing under random spacing
    for (int i = 0; i < 40; i++) begin
      logic [7:0] b = 8'($urandom);
      int gap = int'($urandom % 41);
      repeat (gap) @(negedge clk);
      while (hold_ready !== 1'b1) @(negedge clk);
      write_byte(b); exp_q.push_back(b);
    end
    wait_rx(exp_q.size());
    compare_all("R3");
    wait_ticks(20);
    chk(tx_idle === 1'b1, "R7", "idle at end", int'(tx_idle), 1);
    report();
  end
endmodule